// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block takes asynchronous characters from one serial input line and offers them to a processor through a small byte-wide read/write port. A separate receive clock sets the bit rate. The processor's system clock only runs the bus side and takes no part in bit timing. The receive clock is synchronized into the system clock domain, and each rising edge becomes one oversampling tick. A one-byte mode word, written once after reset, sets two things: the number of ticks that make up one bit time, and the number of data bits in a character.

When the idle line falls, the receiver samples it again half a bit later. A character is assembled only if the line is still low at that point, so a short glitch cannot start a false character. Data bits are sampled in the middle of each bit, least significant bit first. When the stop bit is sampled, the character is copied in parallel to a holding buffer and a ready flag is raised. If a second character completes before the processor has read the first, the first is lost and an overrun flag is set. Writing a command word with its error-reset bit set clears that flag.

Top module: `serial_rx_port`

## Requirements
- R1: Only the first control write (cd=1) after reset is taken as the mode word. Mode bits [1:0] set the ticks per bit: 01 = 1, 10 = 16 and 11 = 64. The code 00 keeps the receiver idle. Any later control write is a command word and leaves the mode unchanged.
- R2: Mode bits [3:2] set the data length: 00 = 5, 01 = 6, 10 = 7 and 11 = 8 bits. Bits arrive least significant first. The buffer holds the character right-aligned, with zeros above it.
- R3: After a falling edge on the idle line, the line is sampled again half a bit time later. If it is high at that point, the receiver returns to idle and no character is produced.
- R4: When the stop bit is sampled, the character moves to the holding buffer and rx_ready goes high. Status bit 0 reports the same flag.
- R5: A data read (cs=1, rd=1, cd=0) returns the buffer on dout and clears rx_ready at that clock edge. A status read (cd=1) returns the status byte.
- R6: If a character completes while rx_ready is still high and no data read happens in that cycle, status bit 1 (overrun) is set. The buffer then holds the newer character.
- R7: A command word with bit 4 set clears the overrun flag.
- R8: A synchronous reset clears the mode, the buffer and all flags, so the status byte reads 00. Until a mode word is written, line activity produces no character.
- R9: Status bit 2 reads 1 once a mode word has been written. Status bits 7:3 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock for the bus side and all registers |
| rst | input | 1 | Synchronous reset, active high |
| rx_clk | input | 1 | Receive clock; each rising edge is one oversampling tick |
| rx_line | input | 1 | Serial data input; idles high |
| cs | input | 1 | Chip select for bus accesses |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| cd | input | 1 | 1 selects the control/status word, 0 selects the data buffer |
| din | input | 8 | Write data: a mode word or a command word |
| dout | output | 8 | Read data: the buffer when cd=0, the status byte when cd=1 |
| rx_ready | output | 1 | High while an unread character sits in the buffer |

## Verification
The bench runs every baud factor and every data length. A receiver that sampled at bit edges, or that aligned short characters wrongly, would return corrupted or shifted bytes. A low pulse shorter than half a bit checks the start recheck: without the recheck, the receiver would raise rx_ready on a phantom character. Two unread characters in a row check that overrun is flagged and that the newer byte is kept. Writing a command word after the mode word checks that the mode register is not rewritten; a design that reloaded it would fall silent, because the command's low bits decode as the idle baud code.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  localparam int DATA_W     = 8;
  localparam int MAX_FACTOR = 64;
  localparam int CNT_W      = $clog2(MAX_FACTOR);
  localparam int IDX_W      = $clog2(DATA_W);
  localparam int ERR_RST_BIT = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} rx_state_t;

  // last tick index of a full bit time (factor - 1)
  function automatic logic [CNT_W-1:0] bit_last(input logic [1:0] code);
    case (code)
      2'b10:   bit_last = CNT_W'(15);
      2'b11:   bit_last = CNT_W'(63);
      default: bit_last = '0;
    endcase
  endfunction

  // last tick index of half a bit (factor/2 - 1); unused for factor 1
  function automatic logic [CNT_W-1:0] half_last(input logic [1:0] code);
    case (code)
      2'b10:   half_last = CNT_W'(7);
      2'b11:   half_last = CNT_W'(31);
      default: half_last = '0;
    endcase
  endfunction

  // index of the final data bit (length - 1)
  function automatic logic [IDX_W-1:0] last_bit(input logic [1:0] len);
    last_bit = IDX_W'(4) + IDX_W'(len);
  endfunction
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_clk,
  input  logic rx_line,
  output logic tick,
  output logic line
);
  logic [STAGES-1:0] clk_q;
  logic [STAGES-1:0] line_q;
  logic              clk_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_q    <= '0;
      line_q   <= '1;
      clk_prev <= 1'b0;
    end else begin
      clk_q    <= {clk_q[STAGES-2:0], rx_clk};
      line_q   <= {line_q[STAGES-2:0], rx_line};
      clk_prev <= clk_q[STAGES-1];
    end
  end

  assign tick = clk_q[STAGES-1] & ~clk_prev;
  assign line = line_q[STAGES-1];
endmodule

// File: rtl/rx_core.sv
module rx_core
  import serial_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              tick,
  input  logic              line,
  input  logic [1:0]        baud_code,
  input  logic [1:0]        len_code,
  output logic              char_done,
  output logic              start_fail,
  output logic [DATA_W-1:0] char_data
);
  rx_state_t         state;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  nb;
  logic [DATA_W-1:0] sh;
  logic              single;

  assign single     = (baud_code == 2'b01);
  assign char_done  = en && tick && state == ST_STOP && cnt == '0;
  assign start_fail = en && tick && state == ST_START && cnt == '0 && line;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      state <= ST_IDLE;
      cnt   <= '0;
      nb    <= '0;
      sh    <= '0;
    end else if (tick) begin
      case (state)
        ST_IDLE: if (!line) begin
          nb <= '0;
          if (single) begin
            state <= ST_DATA;
            cnt   <= '0;
          end else begin
            state <= ST_START;
            cnt   <= half_last(baud_code);
          end
        end
        ST_START: if (cnt == '0) begin
          if (!line) begin
            state <= ST_DATA;
            cnt   <= bit_last(baud_code);
          end else begin
            state <= ST_IDLE;
          end
        end else cnt <= cnt - 1'b1;
        ST_DATA: if (cnt == '0) begin
          sh  <= {line, sh[DATA_W-1:1]};
          cnt <= bit_last(baud_code);
          if (nb == last_bit(len_code)) state <= ST_STOP;
          else nb <= nb + 1'b1;
        end else cnt <= cnt - 1'b1;
        default: if (cnt == '0) state <= ST_IDLE;
                 else cnt <= cnt - 1'b1;
      endcase
    end
  end

  // right-align a short character
  always_comb char_data = sh >> (IDX_W'(DATA_W - 1) - last_bit(len_code));

  assert_false_start_idle_R3: assert property (@(posedge clk) disable iff (rst)
    start_fail |=> state == ST_IDLE);
  assert_off_stays_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !en |=> state == ST_IDLE && !char_done);
endmodule

// File: rtl/host_regs.sv
module host_regs
  import serial_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic              cd,
  input  logic [DATA_W-1:0] din,
  input  logic              char_done,
  input  logic [DATA_W-1:0] char_data,
  output logic [DATA_W-1:0] dout,
  output logic              rx_ready,
  output logic              mode_ok,
  output logic [1:0]        baud_code,
  output logic [1:0]        len_code
);
  logic [3:0]        mode_reg;
  logic [DATA_W-1:0] hold;
  logic              overrun;
  logic              rd_data, mode_wr, cmd_wr, err_clr;
  logic              unused_din_hi;

  assign rd_data = cs && rd && !cd;
  assign mode_wr = cs && wr && cd && !mode_ok;
  assign cmd_wr  = cs && wr && cd && mode_ok;
  assign err_clr = cmd_wr && din[ERR_RST_BIT];
  assign unused_din_hi = ^din[DATA_W-1:ERR_RST_BIT+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_reg <= '0;
      mode_ok  <= 1'b0;
      hold     <= '0;
      rx_ready <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      if (mode_wr) begin
        mode_reg <= din[3:0];
        mode_ok  <= 1'b1;
      end
      if (char_done) hold <= char_data;
      if (char_done)    rx_ready <= 1'b1;
      else if (rd_data) rx_ready <= 1'b0;
      if (char_done && rx_ready && !rd_data) overrun <= 1'b1;
      else if (err_clr)                      overrun <= 1'b0;
    end
  end

  assign baud_code = mode_reg[1:0];
  assign len_code  = mode_reg[3:2];
  assign dout = cd ? {{(DATA_W-3){1'b0}}, mode_ok, overrun, rx_ready} : hold;

  assert_ready_on_load_R4: assert property (@(posedge clk) disable iff (rst)
    char_done |=> rx_ready);
  assert_read_clears_R5: assert property (@(posedge clk) disable iff (rst)
    rd_data && !char_done |=> !rx_ready);
  assert_overrun_set_R6: assert property (@(posedge clk) disable iff (rst)
    char_done && rx_ready && !rd_data |=> overrun);
  assert_err_reset_R7: assert property (@(posedge clk) disable iff (rst)
    err_clr && !char_done |=> !overrun);
  assert_mode_hold_R1: assert property (@(posedge clk) disable iff (rst)
    mode_ok |=> $stable(mode_reg) && mode_ok);
endmodule

// File: rtl/serial_rx_port.sv
module serial_rx_port
  import serial_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_clk,
  input  logic              rx_line,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic              cd,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              rx_ready
);
  logic              tick, line, en, mode_ok;
  logic              char_done, start_fail;
  logic [1:0]        baud_code, len_code;
  logic [DATA_W-1:0] char_data;

  assign en = mode_ok && baud_code != 2'b00;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .rx_clk(rx_clk), .rx_line(rx_line),
    .tick(tick), .line(line));

  rx_core u_core (
    .clk(clk), .rst(rst), .en(en), .tick(tick), .line(line),
    .baud_code(baud_code), .len_code(len_code),
    .char_done(char_done), .start_fail(start_fail), .char_data(char_data));

  host_regs u_regs (
    .clk(clk), .rst(rst), .cs(cs), .rd(rd), .wr(wr), .cd(cd), .din(din),
    .char_done(char_done), .char_data(char_data), .dout(dout),
    .rx_ready(rx_ready), .mode_ok(mode_ok),
    .baud_code(baud_code), .len_code(len_code));

  assert_no_done_without_mode_R8: assert property (@(posedge clk) disable iff (rst)
    !mode_ok |-> !char_done);
endmodule

// File: tb/sim_serial_rx_port.sv
`timescale 1ns/1ps
module sim_serial_rx_port;
  logic clk = 0, rst = 1, rx_clk = 0, rx_line = 1;
  logic cs = 0, rd = 0, wr = 0, cd = 0;
  logic [7:0] din = 0, dout, v;
  logic rx_ready;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;
  always #8 rx_clk = ~rx_clk;

  serial_rx_port u0 (.clk(clk), .rst(rst), .rx_clk(rx_clk), .rx_line(rx_line),
    .cs(cs), .rd(rd), .wr(wr), .cd(cd), .din(din), .dout(dout), .rx_ready(rx_ready));

  // {baud code, length code, data}
  localparam logic [11:0] VEC [0:6] = '{
    {2'b10, 2'b11, 8'hA5}, {2'b11, 2'b11, 8'h3C}, {2'b01, 2'b11, 8'h96},
    {2'b10, 2'b00, 8'hFF}, {2'b10, 2'b01, 8'hC3}, {2'b10, 2'b10, 8'h7E},
    {2'b01, 2'b00, 8'h0B}};

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; rx_line = 1;
    repeat (3) @(negedge clk); rst = 0;
  endtask

  task automatic bus_write(input logic c, input logic [7:0] val);
    @(negedge clk); cs = 1; wr = 1; cd = c; din = val;
    @(negedge clk); cs = 0; wr = 0;
  endtask

  task automatic bus_read(input logic c, output logic [7:0] val);
    @(negedge clk); cs = 1; rd = 1; cd = c; #1 val = dout;
    @(negedge clk); cs = 0; rd = 0;
  endtask

  function automatic int factor(input logic [1:0] code);
    return code == 2'b01 ? 1 : code == 2'b10 ? 16 : 64;
  endfunction

  task automatic send(input logic [7:0] d, input int nbits, input int f);
    @(negedge rx_clk); rx_line = 0;
    repeat (f) @(negedge rx_clk);
    for (int i = 0; i < nbits; i++) begin
      rx_line = d[i];
      repeat (f) @(negedge rx_clk);
    end
    rx_line = 1;
    repeat (f + 2) @(negedge rx_clk);
    repeat (8) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R8: reset state and no reception before a mode word
    do_reset();
    bus_read(1, v); check("R8 status after reset", v, 8'h00);
    check("R8 rx_ready after reset", {7'b0, rx_ready}, 8'h00);
    send(8'h55, 8, 16);
    check("R8 no char without mode", {7'b0, rx_ready}, 8'h00);

    // table walk: R1 baud factors, R2 lengths, R4 ready, R5 read/clear, R9
    for (int k = 0; k < 7; k++) begin
      logic [1:0] b, l;
      logic [7:0] d;
      int n;
      b = VEC[k][11:10]; l = VEC[k][9:8]; d = VEC[k][7:0];
      n = 5 + int'(l);
      do_reset();
      bus_write(1, {4'b0, l, b});
      send(d, n, factor(b));
      bus_read(1, v); check($sformatf("R4 R9 status vec%0d", k), v, 8'h05);
      bus_read(0, v); check($sformatf("R1 R2 data vec%0d", k), v, d & 8'((1 << n) - 1));
      check($sformatf("R5 ready cleared vec%0d", k), {7'b0, rx_ready}, 8'h00);
    end

    // R1: baud code 00 leaves the receiver idle
    do_reset();
    bus_write(1, 8'h0C);
    send(8'h5A, 8, 16);
    bus_read(1, v); check("R1 code 00 idle", v, 8'h04);

    // R3: short low pulse rejected, then a real character received
    do_reset();
    bus_write(1, 8'h0E);
    @(negedge rx_clk); rx_line = 0;
    repeat (3) @(negedge rx_clk); rx_line = 1;
    repeat (200) @(negedge rx_clk);
    bus_read(1, v); check("R3 glitch ignored", v, 8'h04);
    send(8'h5A, 8, 16);
    bus_read(0, v); check("R3 real char after glitch", v, 8'h5A);

    // R6: overrun keeps newer character
    send(8'h11, 8, 16);
    send(8'h22, 8, 16);
    bus_read(1, v); check("R6 overrun status", v, 8'h07);
    bus_read(0, v); check("R6 newer char kept", v, 8'h22);
    bus_read(1, v); check("R6 overrun held after read", v, 8'h06);

    // R7: error reset clears overrun; command leaves mode unchanged (R1)
    bus_write(1, 8'h10);
    bus_read(1, v); check("R7 overrun cleared", v, 8'h04);
    send(8'h33, 8, 16);
    bus_read(0, v); check("R7 R1 mode kept after command", v, 8'h33);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule